// File: doc/BRIEF.md
# Hardware Error Record with Read Interlock

This block is one error-logging record of a reliability bank. Error reporters present a class, a two-bit priority, a containable flag and an information word. The record keeps the most severe error seen since software last cleared it. It raises an overflow flag whenever a second report reaches a record that already holds an error. Software reads the record and releases it through a small register interface. A read-in-progress interlock ensures that a release never discards an error software has not yet read.

The read-in-progress flag is set when the record fills and cleared when a more severe error replaces the held one. A release request takes effect only while the flag is set. Software therefore runs this loop: read the record, claim it by setting the flag if it is clear, release it, then read the status again. If the record is still valid with the flag clear, a newer error arrived and the loop starts over. The record also drives a valid-summary bit for the bank and a signal output that can be enabled per class.

Register map (word offsets on `reg_addr`): 0 header, 1 control, 2 status, 3 information word. Class codes on `rpt_cls`: 0 none, 1 corrected (CE), 2 uncorrected-deferred (UDE), 3 uncorrected-unrecoverable (UUE).

Top module: `err_rec_interlock`

## Requirements
- R1: After reset every status field, the information word and all signal enables read 0, and `sum_valid` and `sig_out` are 0.
- R2: A report with a nonzero class to an empty record makes it valid and stores class, priority and information. It sets read-in-progress (status bit 7) and clears overflow (status bit 6). Status bit 0 is valid, bits 2:1 class, bits 4:3 priority and bit 5 containable.
- R3: A report to a valid record replaces its contents only if its class code is larger, or its class is equal and its priority is larger. A replacement clears read-in-progress. Any report to a valid record, whether it replaces the contents or is dropped, sets overflow.
- R4: Writing control bit 0 (release) clears valid, overflow and read-in-progress only when read-in-progress is 1. Otherwise the record is unchanged.
- R5: Writing control bit 1 sets read-in-progress while the record is valid.
- R6: While valid is 1, writes to the status register change nothing. While valid is 0, such a write loads the class, priority and containable fields.
- R7: The containable bit is stored only with class UUE and reads 0 for any other class.
- R8: The header register reads layout 0 in bits 2:0 and the valid summary in bit 8.
- R9: `sum_valid` equals the record's valid bit.
- R10: `sig_out` is 1 exactly while the record is valid and the enable for its class is set. Control bits 2, 3 and 4 enable CE, UDE and UUE, and control reads return those enables.
- R11: A report in the same cycle as a register write takes precedence, and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_vld | input | 1 | Error report strobe |
| rpt_cls | input | 2 | Report class code |
| rpt_pri | input | 2 | Report priority |
| rpt_cont | input | 1 | Report containable flag |
| rpt_info | input | INFO_W | Report address or information word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| sum_valid | output | 1 | Valid summary bit for the bank |
| sig_out | output | 1 | Per-record error signal |

## Verification
Every report and register write updates the record on the first rising edge after it is presented. Register reads are combinational from the stored state, so each result is visible one cycle after its stimulus. The bench drives all inputs on falling edges and reads back one falling edge after the capturing rising edge. It sweeps every ordered pair of the twelve class and priority combinations. For each pair it computes the replace-or-drop outcome arithmetically and follows the release loop to the empty state.

// File: rtl/err_rec_pkg.sv
package err_rec_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_CE   = 2'd1,
    CLS_UDE  = 2'd2,
    CLS_UUE  = 2'd3
  } err_cls_e;

  typedef struct packed {
    logic       rdip;
    logic       ovf;
    logic       cont;
    logic [1:0] pri;
    logic [1:0] cls;
    logic       valid;
  } rec_stat_t;

  localparam int unsigned NUM_CLS   = 3;
  localparam logic [1:0]  A_HEADER  = 2'd0;
  localparam logic [1:0]  A_CTRL    = 2'd1;
  localparam logic [1:0]  A_STATUS  = 2'd2;
  localparam logic [1:0]  A_INFO    = 2'd3;
  localparam logic [2:0]  LAYOUT_ID = 3'd0;
endpackage

// File: rtl/err_rec_rank.sv
module err_rec_rank (
  input  logic [1:0] new_cls,
  input  logic [1:0] new_pri,
  input  logic [1:0] old_cls,
  input  logic [1:0] old_pri,
  output logic       higher
);
  logic [3:0] new_rank;
  logic [3:0] old_rank;

  always_comb begin
    new_rank = {new_cls, new_pri};
    old_rank = {old_cls, old_pri};
    higher   = new_rank > old_rank;
  end
endmodule

// File: rtl/err_rec_sig.sv
module err_rec_sig
  import err_rec_pkg::*;
(
  input  logic               valid,
  input  logic [1:0]         cls,
  input  logic [NUM_CLS-1:0] en,
  output logic               sig
);
  logic [NUM_CLS-1:0] hit;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    assign hit[g] = valid && (cls == 2'(g + 1)) && en[g];
  end

  assign sig = |hit;
endmodule

// File: rtl/err_rec_update.sv
module err_rec_update
  import err_rec_pkg::*;
#(
  parameter int unsigned INFO_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  rec_stat_t          st_q,
  input  logic [NUM_CLS-1:0] en_q,
  input  logic [INFO_W-1:0]  info_q,
  input  logic               rpt_vld,
  input  logic [1:0]         rpt_cls,
  input  logic [1:0]         rpt_pri,
  input  logic               rpt_cont,
  input  logic [INFO_W-1:0]  rpt_info,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               higher,
  output rec_stat_t          st_d,
  output logic [NUM_CLS-1:0] en_d,
  output logic [INFO_W-1:0]  info_d,
  output logic               upd_en
);
  logic hw_evt;

  always_comb begin
    hw_evt = rpt_vld && (rpt_cls != CLS_NONE);
    st_d   = st_q;
    en_d   = en_q;
    info_d = info_q;
    if (hw_evt) begin
      if (!st_q.valid || higher) begin
        st_d.cls   = rpt_cls;
        st_d.pri   = rpt_pri;
        st_d.cont  = rpt_cont && (rpt_cls == CLS_UUE);
        info_d     = rpt_info;
      end
      if (!st_q.valid) begin
        st_d.valid = 1'b1;
        st_d.rdip  = 1'b1;
        st_d.ovf   = 1'b0;
      end else begin
        st_d.ovf   = 1'b1;
        if (higher) st_d.rdip = 1'b0;
      end
    end else if (reg_wr) begin
      unique case (reg_addr)
        A_CTRL: begin
          en_d = reg_wdata[2 +: NUM_CLS];
          if (reg_wdata[1] && st_q.valid) st_d.rdip = 1'b1;
          if (reg_wdata[0] && st_q.rdip) begin
            st_d.valid = 1'b0;
            st_d.ovf   = 1'b0;
            st_d.rdip  = 1'b0;
          end
        end
        A_STATUS: begin
          if (!st_q.valid) begin
            st_d.cls  = reg_wdata[2:1];
            st_d.pri  = reg_wdata[4:3];
            st_d.cont = reg_wdata[5] && (reg_wdata[2:1] == CLS_UUE);
          end
        end
        default: ;
      endcase
    end
    upd_en = hw_evt || reg_wr;
  end
endmodule

// File: rtl/err_rec_interlock.sv
module err_rec_interlock
  import err_rec_pkg::*;
#(
  parameter int unsigned INFO_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_vld,
  input  logic [1:0]        rpt_cls,
  input  logic [1:0]        rpt_pri,
  input  logic              rpt_cont,
  input  logic [INFO_W-1:0] rpt_info,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sum_valid,
  output logic              sig_out
);
  localparam int unsigned EN_LSB = 2;

  rec_stat_t          st_q, st_d;
  logic [NUM_CLS-1:0] en_q, en_d;
  logic [INFO_W-1:0]  info_q, info_d;
  logic               upd_en;
  logic               higher;
  logic [7:0]         stat_word;

  err_rec_rank u_rank (
    .new_cls (rpt_cls),
    .new_pri (rpt_pri),
    .old_cls (st_q.cls),
    .old_pri (st_q.pri),
    .higher  (higher)
  );

  err_rec_update #(.INFO_W(INFO_W), .DATA_W(DATA_W)) u_upd (
    .st_q      (st_q),
    .en_q      (en_q),
    .info_q    (info_q),
    .rpt_vld   (rpt_vld),
    .rpt_cls   (rpt_cls),
    .rpt_pri   (rpt_pri),
    .rpt_cont  (rpt_cont),
    .rpt_info  (rpt_info),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .higher    (higher),
    .st_d      (st_d),
    .en_d      (en_d),
    .info_d    (info_d),
    .upd_en    (upd_en)
  );

  err_rec_sig u_sig (
    .valid (st_q.valid),
    .cls   (st_q.cls),
    .en    (en_q),
    .sig   (sig_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      info_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      en_q   <= en_d;
      info_q <= info_d;
    end
  end

  always_comb begin
    stat_word = st_q;
    sum_valid = st_q.valid;
    reg_rdata = '0;
    unique case (reg_addr)
      A_HEADER: begin
        reg_rdata[2:0] = LAYOUT_ID;
        reg_rdata[8]   = st_q.valid;
      end
      A_CTRL:   reg_rdata[EN_LSB +: NUM_CLS] = en_q;
      A_STATUS: reg_rdata[7:0] = stat_word;
      A_INFO:   reg_rdata = DATA_W'(info_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/err_rec_interlock_chk.sv
module err_rec_interlock_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rpt_vld,
  input logic [1:0]        rpt_cls,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sum_valid,
  input logic              sig_out,
  input logic [7:0]        stat
);
  // R2
  rdip_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> stat[7]);

  // R3
  ovf_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat[0] && rpt_vld && rpt_cls != 2'd0) |-> stat[6]);

  // R4
  release_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |-> $past(stat[7]));

  // R4
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[6]) |-> $fell(stat[0]));

  // R6
  stat_wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat[0] && reg_wr && reg_addr == 2'd2 && !(rpt_vld && rpt_cls != 2'd0))
      |-> $stable(stat[5:1]));

  // R7
  cont_uue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat[5] |-> stat[2:1] == 2'd3);

  // R9
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid == stat[0]);

  // R10
  sig_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_out |-> stat[0]);

  // R8
  always_comb begin
    if (rst_n && reg_addr == 2'd0) begin
      layout_zero_chk: assert (reg_rdata[2:0] == 3'd0);
    end
  end
endmodule

bind err_rec_interlock err_rec_interlock_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rpt_vld   (rpt_vld),
  .rpt_cls   (rpt_cls),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .sum_valid (sum_valid),
  .sig_out   (sig_out),
  .stat      (stat_word)
);

// File: tb/err_rec_interlock_tb_top.sv
`timescale 1ns/1ps
module err_rec_interlock_tb_top;
  localparam int INFO_W = 32;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rpt_vld = 1'b0;
  logic [1:0]        rpt_cls = '0;
  logic [1:0]        rpt_pri = '0;
  logic              rpt_cont = 1'b0;
  logic [INFO_W-1:0] rpt_info = '0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              sum_valid;
  logic              sig_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  err_rec_interlock #(.INFO_W(INFO_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rpt_vld(rpt_vld), .rpt_cls(rpt_cls),
    .rpt_pri(rpt_pri), .rpt_cont(rpt_cont), .rpt_info(rpt_info),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sum_valid(sum_valid), .sig_out(sig_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report(logic [1:0] c, logic [1:0] p, logic ct, logic [31:0] inf);
    @(negedge clk);
    rpt_vld = 1'b1; rpt_cls = c; rpt_pri = p; rpt_cont = ct; rpt_info = inf;
    @(negedge clk);
    rpt_vld = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] stat_of(logic v, logic [1:0] c, logic [1:0] p,
                                         logic ct, logic o, logic r);
    return {r, o, ct, p, c, v};
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  exp_st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, d); check("R1 status", d, 0);
    rd(2'd3, d); check("R1 info", d, 0);
    rd(2'd1, d); check("R1 ctrl", d, 0);
    check("R1 sum/sig", {sum_valid, sig_out}, 0);
    // R8 header
    rd(2'd0, d); check("R8 header", d, 0);

    // R2/R3/R4/R5/R7/R9 exhaustive pair sweep
    for (int a = 0; a < 12; a++) begin
      for (int b = 0; b < 12; b++) begin
        logic [1:0] c1, p1, c2, p2;
        logic over;
        c1 = 2'(a / 4 + 1); p1 = 2'(a % 4);
        c2 = 2'(b / 4 + 1); p2 = 2'(b % 4);
        over = (c2 > c1) || (c2 == c1 && p2 > p1);
        report(c1, p1, 1'b1, 32'(a * 16 + 1));
        rd(2'd2, d);
        check("R2 fill", d, stat_of(1, c1, p1, c1 == 2'd3, 0, 1));
        check("R9 sum", sum_valid, 1);
        report(c2, p2, 1'b1, 32'(b * 16 + 2));
        rd(2'd2, d);
        exp_st = over ? stat_of(1, c2, p2, c2 == 2'd3, 1, 0)
                      : stat_of(1, c1, p1, c1 == 2'd3, 1, 1);
        check("R3 R7 second report", d, exp_st);
        rd(2'd3, d);
        check("R3 info", d, over ? 32'(b * 16 + 2) : 32'(a * 16 + 1));
        wr(2'd1, 32'h1);
        rd(2'd2, d);
        check("R4 release", d[0], over ? 1 : 0);
        if (over) begin
          wr(2'd1, 32'h2);
          rd(2'd2, d); check("R5 claim", d[7], 1);
          wr(2'd1, 32'h1);
          rd(2'd2, d); check("R4 release after claim", d[7:0] & 8'hC1, 0);
        end else begin
          check("R4 ovf cleared", d[7:6], 0);
        end
        check("R9 sum clear", sum_valid, 0);
      end
    end

    // R6 status write locked while valid, loads when empty
    report(2'd2, 2'd1, 1'b0, 32'hA5);
    wr(2'd2, 32'h3E);
    rd(2'd2, d); check("R6 locked", d[7:0], stat_of(1, 2, 1, 0, 0, 1));
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h3E);
    rd(2'd2, d); check("R6 load when empty", d[7:0], stat_of(0, 3, 3, 1, 0, 0));
    wr(2'd2, 32'h22);
    rd(2'd2, d); check("R7 cont non-UUE", d[5], 0);
    // R5 claim has no effect when empty
    wr(2'd1, 32'h2);
    rd(2'd2, d); check("R5 empty claim", d[7], 0);

    // R10 signal enables
    wr(2'd1, 32'h8);
    rd(2'd1, d); check("R10 ctrl read", d, 32'h8);
    report(2'd1, 2'd0, 1'b0, 32'h1);
    check("R10 CE disabled", sig_out, 0);
    report(2'd2, 2'd0, 1'b0, 32'h2);
    check("R10 UDE enabled", sig_out, 1);

    // R11 report wins over same-cycle write
    @(negedge clk);
    rpt_vld = 1'b1; rpt_cls = 2'd3; rpt_pri = 2'd0; rpt_cont = 1'b1; rpt_info = 32'h3;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1D;
    @(negedge clk);
    rpt_vld = 1'b0; reg_wr = 1'b0;
    rd(2'd2, d); check("R11 report wins", d[7:0], stat_of(1, 3, 0, 1, 1, 0));
    rd(2'd1, d); check("R11 ctrl discarded", d, 32'h8);
    check("R10 UUE disabled", sig_out, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule